// File: doc/BRIEF.md
# Vector Mask Compress and Expand Unit

This block moves elements between vector registers under a per-element mask, one element per clock. In compress mode it walks the source register from element 0 upward and writes every element whose mask bit is set into the next free slot of the destination, starting at slot 0. The number of written elements, which is the population count of the live mask bits, is reported as the new vector length. In expand mode it does the opposite. It reads the packed source from element 0 upward and places each element at the destination position of the next set mask bit. Positions whose bit is clear are never written, so they keep their previous contents.

The unit connects to a register file through one read port and one write port. The read port is combinational: the data for `rd_idx_o` must be valid on `rd_data_i` in the same cycle. The write port is a write strobe with an index and data, and the register file captures it on the rising edge. An operation is launched with a one-cycle `start_i` while the unit is idle. Only the first `vl_i` elements take part, and `done_o` pulses when the operation is complete.

Control is a three-state machine:
- `ST_IDLE` waits for `start_i`. On start it goes to `ST_RUN`, or straight to `ST_DONE` when the vector length is zero.
- `ST_RUN` handles one element per cycle. It moves to `ST_DONE` after the last live element.
- `ST_DONE` raises `done_o` for one cycle and always returns to `ST_IDLE`.

Top module: `vcx_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy_o`, `done_o` and `wr_en_o` are 0 and `new_vl_o` is 0.
- R2: With `op_i`=0 (compress), mask bit i belongs to source element i. The k-th set bit, counting from the lowest index, causes source element i to be written to destination slot k, so the selected elements keep their relative order.
- R3: Compress writes no destination slot at or above the packed length; those slots keep their previous contents.
- R4: With `op_i`=1 (expand), the k-th set mask bit at position i causes packed source element k to be written to destination position i.
- R5: Expand never writes a destination position whose mask bit is clear; those positions keep their previous contents.
- R6: `new_vl_o` becomes the number of set mask bits below the vector length when `done_o` rises, and it holds that value until the next operation completes.
- R7: Mask bits at positions at or above the vector length have no effect on writes or on `new_vl_o`.
- R8: `done_o` is high for exactly one cycle: the cycle after the (L+1)-th rising edge, counting the edge that samples `start_i`, where L is the effective length. `busy_o` is high for the L cycles in between.
- R9: An all-zero live mask, or a length of zero, produces no writes and `new_vl_o`=0, and `done_o` still pulses.
- R10: A `vl_i` value above VLMAX is treated as VLMAX.
- R11: `start_i` is ignored while `busy_o` or `done_o` is high. The running operation finishes with its original mode, mask and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch an operation (sampled only in ST_IDLE) |
| op_i | input | 1 | 0 = compress, 1 = expand |
| vl_i | input | LW | Vector length, clamped to VLMAX |
| mask_i | input | VLMAX | Per-element select mask, bit i for element i |
| busy_o | output | 1 | High while elements are being processed |
| done_o | output | 1 | One-cycle completion pulse |
| new_vl_o | output | LW | Population count of the live mask bits |
| rd_idx_o | output | IW | Source register read index |
| rd_data_i | input | EW | Source element at rd_idx_o, same cycle |
| wr_en_o | output | 1 | Destination write strobe |
| wr_idx_o | output | IW | Destination write index |
| wr_data_o | output | EW | Destination write data |

## Verification
The assertions assume the following about the inputs:
- The source register file returns data for `rd_idx_o` combinationally.
- The mode, mask and length are valid in the cycle that `start_i` is sampled.
- Pulses on `start_i` outside `ST_IDLE` must not disturb the operation already running.

The stimulus meets these conditions. It drives every input half a cycle away from the sampling edge, and it serves reads from a bench-side array indexed directly by `rd_idx_o`. It deliberately raises `start_i` during a running operation so that the assumption about ignored starts is exercised rather than merely relied on. The length and mask table covers both modes, the full, partial, zero and above-maximum lengths, and masks with bits set beyond the length.

// File: rtl/vcx_pkg.sv
package vcx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vcx_state_e;

    localparam logic OP_PACK   = 1'b0;
    localparam logic OP_UNPACK = 1'b1;

endpackage

// File: rtl/vcx_ctrl.sv
module vcx_ctrl
    import vcx_pkg::*;
#(
    parameter int VLMAX = 8,
    parameter int LW    = 4,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_i,
    input  logic [LW-1:0]    vl_i,
    input  logic [VLMAX-1:0] mask_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             accept_o,
    output logic             finish_o,
    output logic             sel_o,
    output logic [IW-1:0]    idx_o,
    output logic             op_q_o,
    output logic [LW-1:0]    vl_q_o
);

    localparam logic [LW-1:0] LEN_MAX = LW'(VLMAX);
    localparam logic [LW-1:0] LEN_ONE = LW'(1);

    vcx_state_e       state_q, state_d;
    logic [IW-1:0]    idx_q;
    logic [LW-1:0]    vl_q;
    logic [VLMAX-1:0] mask_q;
    logic             op_q;
    logic [LW-1:0]    vl_eff;
    logic             last_elem;

    // Clamp the requested length to the register size.
    assign vl_eff    = (vl_i > LEN_MAX) ? LEN_MAX : vl_i;
    assign last_elem = ((LW'(idx_q) + LEN_ONE) == vl_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and launch/finish strobes
    always_comb begin
        state_d  = state_q;
        accept_o = 1'b0;
        finish_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept_o = 1'b1;
                    if (vl_eff == '0) begin
                        state_d  = ST_DONE;
                        finish_o = 1'b1;
                    end else begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (last_elem) begin
                    state_d  = ST_DONE;
                    finish_o = 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs decoded from the current state
    always_comb begin
        busy_o = 1'b0;
        done_o = 1'b0;
        sel_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
            end
            ST_RUN: begin
                busy_o = 1'b1;
                sel_o  = mask_q[idx_q];
            end
            ST_DONE: begin
                done_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    // Operation context captured at launch, element walker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            vl_q   <= '0;
            mask_q <= '0;
            op_q   <= OP_PACK;
        end else if (accept_o) begin
            idx_q  <= '0;
            vl_q   <= vl_eff;
            mask_q <= mask_i;
            op_q   <= op_i;
        end else if (state_q == ST_RUN) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o  = idx_q;
    assign op_q_o = op_q;
    assign vl_q_o = vl_q;

endmodule

// File: rtl/vcx_count.sv
module vcx_count #(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          inc_i,
    input  logic          finish_i,
    output logic [LW-1:0] cnt_o,
    output logic [LW-1:0] len_o
);

    logic [LW-1:0] cnt_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] cnt_next;

    assign cnt_next = cnt_q + (inc_i ? LW'(1) : LW'(0));

    // Running count of selected elements
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next;
        end
    end

    // Result length, updated only when an operation finishes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (finish_i) begin
            len_q <= clear_i ? '0 : cnt_next;
        end
    end

    assign cnt_o = cnt_q;
    assign len_o = len_q;

endmodule

// File: rtl/vcx_route.sv
module vcx_route
    import vcx_pkg::*;
#(
    parameter int EW = 16,
    parameter int LW = 4,
    parameter int IW = 3
) (
    input  logic          op_i,
    input  logic          sel_i,
    input  logic [IW-1:0] idx_i,
    input  logic [LW-1:0] cnt_i,
    input  logic [EW-1:0] rd_data_i,
    output logic [IW-1:0] rd_idx_o,
    output logic          wr_en_o,
    output logic [IW-1:0] wr_idx_o,
    output logic [EW-1:0] wr_data_o
);

    logic [IW-1:0] slot;

    // The running count is below VLMAX while elements are walked.
    assign slot = cnt_i[IW-1:0];

    always_comb begin
        if (op_i == OP_PACK) begin
            rd_idx_o = idx_i;
            wr_idx_o = slot;
        end else begin
            rd_idx_o = slot;
            wr_idx_o = idx_i;
        end
        wr_en_o   = sel_i;
        wr_data_o = rd_data_i;
    end

endmodule

// File: rtl/vcx_unit.sv
module vcx_unit #(
    parameter  int VLMAX = 8,
    parameter  int EW    = 16,
    localparam int IW    = (VLMAX > 1) ? $clog2(VLMAX) : 1,
    localparam int LW    = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_i,
    input  logic [LW-1:0]    vl_i,
    input  logic [VLMAX-1:0] mask_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [LW-1:0]    new_vl_o,
    output logic [IW-1:0]    rd_idx_o,
    input  logic [EW-1:0]    rd_data_i,
    output logic             wr_en_o,
    output logic [IW-1:0]    wr_idx_o,
    output logic [EW-1:0]    wr_data_o
);

    logic          accept;
    logic          finish;
    logic          sel;
    logic [IW-1:0] idx;
    logic          op_q;
    logic [LW-1:0] vl_q;
    logic [LW-1:0] cnt;

    vcx_ctrl #(
        .VLMAX(VLMAX),
        .LW   (LW),
        .IW   (IW)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_i    (op_i),
        .vl_i    (vl_i),
        .mask_i  (mask_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .accept_o(accept),
        .finish_o(finish),
        .sel_o   (sel),
        .idx_o   (idx),
        .op_q_o  (op_q),
        .vl_q_o  (vl_q)
    );

    vcx_count #(
        .LW(LW)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .inc_i   (sel),
        .finish_i(finish),
        .cnt_o   (cnt),
        .len_o   (new_vl_o)
    );

    vcx_route #(
        .EW(EW),
        .LW(LW),
        .IW(IW)
    ) u_route (
        .op_i     (op_q),
        .sel_i    (sel),
        .idx_i    (idx),
        .cnt_i    (cnt),
        .rd_data_i(rd_data_i),
        .rd_idx_o (rd_idx_o),
        .wr_en_o  (wr_en_o),
        .wr_idx_o (wr_idx_o),
        .wr_data_o(wr_data_o)
    );

endmodule

// File: rtl/vcx_unit_chk.sv
module vcx_unit_chk
    import vcx_pkg::*;
#(
    parameter int VLMAX = 8,
    parameter int LW    = 4,
    parameter int IW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          wr_en_o,
    input logic [IW-1:0] wr_idx_o,
    input logic [IW-1:0] rd_idx_o,
    input logic [LW-1:0] new_vl_o,
    input logic [LW-1:0] vl_q,
    input logic          op_q
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o); // R9

    AST_PACK_SLOT_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && op_q == OP_PACK) |-> (wr_idx_o <= rd_idx_o)); // R2

    AST_UNPACK_POS_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && op_q == OP_UNPACK) |-> (wr_idx_o >= rd_idx_o)); // R4

    AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(new_vl_o)); // R6

    AST_LEN_WITHIN_VL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (new_vl_o <= vl_q)); // R7

    AST_VL_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (vl_q <= LW'(VLMAX))); // R10

    AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R11

endmodule

bind vcx_unit vcx_unit_chk #(
    .VLMAX(VLMAX),
    .LW   (LW),
    .IW   (IW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .wr_en_o (wr_en_o),
    .wr_idx_o(wr_idx_o),
    .rd_idx_o(rd_idx_o),
    .new_vl_o(new_vl_o),
    .vl_q    (vl_q),
    .op_q    (op_q)
);

// File: tb/vcx_unit_bench.sv
`timescale 1ns/1ps
module vcx_unit_bench;

    localparam int VLMAX = 8;
    localparam int EW    = 16;
    localparam int IW    = 3;
    localparam int LW    = 4;
    localparam int CLK_P = 20;
    localparam int NVEC  = 9;

    // {op, vl, mask}
    localparam logic [12:0] TBL [NVEC] = '{
        {1'b0, 4'd8,  8'hB2},
        {1'b0, 4'd8,  8'hFF},
        {1'b0, 4'd5,  8'hF0},
        {1'b1, 4'd8,  8'hB2},
        {1'b1, 4'd8,  8'h01},
        {1'b1, 4'd6,  8'hC3},
        {1'b0, 4'd8,  8'h00},
        {1'b0, 4'd0,  8'hFF},
        {1'b1, 4'd15, 8'h81}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             op = 1'b0;
    logic [LW-1:0]    vl = '0;
    logic [VLMAX-1:0] mask = '0;
    logic             busy, done, wr_en;
    logic [LW-1:0]    new_vl;
    logic [IW-1:0]    rd_idx, wr_idx;
    logic [EW-1:0]    rd_data, wr_data;
    logic             preload = 1'b0;

    logic [EW-1:0] src_mem [VLMAX];
    logic [EW-1:0] dst_mem [VLMAX];
    logic [EW-1:0] exp_mem [VLMAX];
    int            exp_len;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    vcx_unit #(.VLMAX(VLMAX), .EW(EW)) u_vcx_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .vl_i(vl),
        .mask_i(mask), .busy_o(busy), .done_o(done), .new_vl_o(new_vl),
        .rd_idx_o(rd_idx), .rd_data_i(rd_data), .wr_en_o(wr_en),
        .wr_idx_o(wr_idx), .wr_data_o(wr_data)
    );

    assign rd_data = src_mem[rd_idx];

    always @(posedge clk) begin
        if (preload) begin
            for (int i = 0; i < VLMAX; i++) dst_mem[i] <= EW'(16'hD000 + i);
        end else if (wr_en) begin
            dst_mem[wr_idx] <= wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Expected destination contents, from the requirements
    task automatic compute_exp(input logic o, input logic [LW-1:0] l,
                               input logic [VLMAX-1:0] m);
        int len;
        int k;
        len = (int'(l) > VLMAX) ? VLMAX : int'(l);
        k = 0;
        for (int i = 0; i < VLMAX; i++) exp_mem[i] = EW'(16'hD000 + i);
        for (int i = 0; i < len; i++) begin
            if (m[i]) begin
                if (o == 1'b0) exp_mem[k] = src_mem[i];
                else           exp_mem[i] = src_mem[k];
                k++;
            end
        end
        exp_len = k;
    endtask

    task automatic check_dst(input string req);
        int bad;
        int first_act;
        int first_exp;
        bad = 0; first_act = 0; first_exp = 0;
        for (int i = 0; i < VLMAX; i++) begin
            if (dst_mem[i] !== exp_mem[i]) begin
                if (bad == 0) begin
                    first_act = int'(dst_mem[i]);
                    first_exp = int'(exp_mem[i]);
                end
                bad++;
            end
        end
        chk(bad == 0, req, "destination contents", first_act, first_exp);
    endtask

    task automatic do_preload();
        @(negedge clk); preload = 1'b1;
        @(posedge clk);
        @(negedge clk); preload = 1'b0;
    endtask

    task automatic run_op(input logic o, input logic [LW-1:0] l,
                          input logic [VLMAX-1:0] m, output int cyc);
        start = 1'b1; op = o; vl = l; mask = m;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        cyc = 1;
        while (!done && cyc < 64) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int cyc;
        int explen;
        for (int i = 0; i < VLMAX; i++) src_mem[i] = EW'(16'hA000 + i);

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_en == 1'b0, "R1", "wr_en after reset", int'(wr_en), 0);
        chk(new_vl == '0, "R1", "new_vl after reset", int'(new_vl), 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int t = 0; t < NVEC; t++) begin
            logic          t_op;
            logic [LW-1:0] t_vl;
            logic [7:0]    t_mask;
            int            eff;
            t_op   = TBL[t][12];
            t_vl   = TBL[t][11:8];
            t_mask = TBL[t][7:0];
            eff    = (int'(t_vl) > VLMAX) ? VLMAX : int'(t_vl);
            do_preload();
            compute_exp(t_op, t_vl, t_mask);
            run_op(t_op, t_vl, t_mask, cyc);
            chk(cyc == eff + 1, "R8", "cycles start to done", cyc, eff + 1);
            chk(int'(new_vl) == exp_len, "R6", "packed length (R7 R9 R10)",
                int'(new_vl), exp_len);
            @(negedge clk);
            if (t_op == 1'b0) check_dst("R2 R3");
            else              check_dst("R4 R5");
        end

        // R8 / R6: done is a single pulse and the length is held while idle
        explen = exp_len;
        chk(done == 1'b0, "R8", "done after pulse", int'(done), 0);
        repeat (5) @(negedge clk);
        chk(int'(new_vl) == explen, "R6", "length held while idle",
            int'(new_vl), explen);
        chk(busy == 1'b0, "R8", "busy while idle", int'(busy), 0);

        // R11: start pulsed during a run with another mode, mask and length
        do_preload();
        compute_exp(1'b0, 4'd8, 8'hB2);
        start = 1'b1; op = 1'b0; vl = 4'd8; mask = 8'hB2;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; op = 1'b1; vl = 4'd2; mask = 8'hFF;
        @(negedge clk); start = 1'b0;
        cyc = 5;
        while (!done && cyc < 64) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == 9, "R11", "cycles with ignored start", cyc, 9);
        chk(int'(new_vl) == 4, "R11", "length with ignored start", int'(new_vl), 4);
        start = 1'b1; op = 1'b1; vl = 4'd2; mask = 8'hFF;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b0, "R11", "start in done state ignored", int'(busy), 0);
        check_dst("R11");

        // R9: empty mask after a previous non-zero result gives length 0
        do_preload();
        compute_exp(1'b1, 4'd8, 8'h00);
        run_op(1'b1, 4'd8, 8'h00, cyc);
        chk(new_vl == '0, "R9", "empty expand length", int'(new_vl), 0);
        @(negedge clk);
        check_dst("R9");

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule